// File: doc/BRIEF.md
# Snoop control register block

This block is the register slave for the 256-byte control window of a small coherent multicore cluster. A simple strobe bus reaches it, with byte offset, read and write strobes, an access size in bytes and 32-bit write data. It holds an enable bit, a read-only identification word derived from the number of cores, and a 32-bit power status word. Software may write the power status word one byte, one half-word or one word at a time, starting at any of its four byte offsets.

Cache maintenance, address filtering and secure access control are not implemented. Their locations still decode. The maintenance location accepts writes and does nothing. The two filter locations read as zero and ignore writes. The access control locations are treated like any unmapped offset. An access to an unmapped offset, or with an illegal size, raises a one-cycle error pulse and leaves the state as it was.

Read data and the error flag are registered. Both appear in the cycle after the strobe. The read data then holds until the next read.

Top module: `snoop_ctl_regs`

## Requirements
- R1: After reset, the enable bit, the power status word, the read data and the error flag are all zero.
- R2: A legal-size write to offset 0x00 stores write-data bit 0 as the enable bit. A read of 0x00 returns the enable bit in bit 0 and zero in bits 31:1.
- R3: A read of offset 0x04 returns N-1 in bits 3:0, ones in bits 4 to 3+N and zero above, where N is the NUM_CPU parameter. Writes to 0x04 change nothing and raise no error.
- R4: A legal-size write to offset 0x08+k (k = 0..3) replaces power status bits starting at bit 8k with the low 1, 2 or 4 bytes of the write data. Bytes that would land above bit 31 are discarded, and all other bits keep their value.
- R5: A read of offset 0x08+k returns the power status word shifted right by 8k bits, with zeros filling in from the top.
- R6: A write to offset 0x0C completes without error and changes no state. A read of 0x0C returns zero without error.
- R7: Offsets 0x40 and 0x44 read as zero, ignore writes and raise no error.
- R8: Every other offset, including 0x50 and 0x54, is unmapped. A read there returns zero, a write there changes nothing, and either one raises the error flag.
- R9: The size input carries the byte count: 1, 2 and 4 are legal. Any other value raises the error flag, changes no state and makes a read return zero.
- R10: The read data and the error flag update on the clock edge that samples the strobe. The error flag is high only in the cycle after a faulty access, and the read data holds its value through cycles with no read.
- R11: NUM_CPU must lie between 1 and 4. Elaboration fails for any other value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 8 | Byte offset within the window |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_size | input | 3 | Access size in bytes (1, 2 or 4) |
| bus_wdata | input | 32 | Write data, right-aligned |
| bus_rdata | output | 32 | Registered read data |
| bus_err | output | 1 | One-cycle error pulse for an unmapped offset or an illegal size |

## Verification
The read path is swept over all 256 offsets and all eight size codes. This separates mapped locations from unmapped ones, legal sizes from illegal ones, and each power status alignment from its neighbours. Power status writes are tried at every byte offset with each legal size and several distinct byte patterns. Reading all four offsets afterwards exposes a wrong lane shift, a lost high byte or a clobbered neighbour. Writes to the identification word, the maintenance location, the filter locations, every unmapped offset and with illegal sizes are each followed by reads of the enable bit and the power status word. A write that leaks into either one shows up there.

// File: rtl/snoop_ctl_pkg.sv
package snoop_ctl_pkg;

  localparam int OFS_W      = 8;
  localparam int WORD_W     = 32;
  localparam int LANE_W     = 8;
  localparam int LANES      = WORD_W / LANE_W;
  localparam int LANE_IDX_W = $clog2(LANES);
  localparam int SIZE_W     = 3;
  localparam int CPU_LSB    = 4;
  localparam int MAX_CPU    = 4;

  localparam logic [OFS_W-1:0] OFS_ENABLE   = 8'h00;
  localparam logic [OFS_W-1:0] OFS_IDENT    = 8'h04;
  localparam logic [OFS_W-1:0] OFS_PWR_BASE = 8'h08;
  localparam logic [OFS_W-1:0] OFS_FLUSH    = 8'h0C;
  localparam logic [OFS_W-1:0] OFS_FILT_LO  = 8'h40;
  localparam logic [OFS_W-1:0] OFS_FILT_HI  = 8'h44;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_ENABLE,
    SEL_IDENT,
    SEL_PWR,
    SEL_FLUSH,
    SEL_ZERO
  } sel_e;

  // Legal access sizes are byte counts 1, 2 and 4.
  function automatic logic size_legal(input logic [SIZE_W-1:0] sz);
    return (sz == 3'd1) || (sz == 3'd2) || (sz == 3'd4);
  endfunction

endpackage

// File: rtl/snoop_ctl_decode.sv
module snoop_ctl_decode
  import snoop_ctl_pkg::*;
(
  input  logic [OFS_W-1:0]      ofs,
  input  logic [SIZE_W-1:0]     size,
  output sel_e                  sel,
  output logic [LANE_IDX_W-1:0] lane,
  output logic                  size_ok,
  output logic                  fault
);

  always_comb begin
    sel  = SEL_NONE;
    lane = ofs[LANE_IDX_W-1:0];
    case (ofs)
      OFS_ENABLE:               sel = SEL_ENABLE;
      OFS_IDENT:                sel = SEL_IDENT;
      OFS_FLUSH:                sel = SEL_FLUSH;
      OFS_FILT_LO, OFS_FILT_HI: sel = SEL_ZERO;
      default: begin
        if (ofs[OFS_W-1:LANE_IDX_W] == OFS_PWR_BASE[OFS_W-1:LANE_IDX_W]) begin
          sel = SEL_PWR;
        end
      end
    endcase
    size_ok = size_legal(size);
    fault   = !size_ok || (sel == SEL_NONE);
  end

endmodule

// File: rtl/snoop_ctl_ident.sv
module snoop_ctl_ident
  import snoop_ctl_pkg::*;
#(
  parameter int NUM_CPU = 2
) (
  output logic [WORD_W-1:0] word
);

  for (genvar b = 0; b < WORD_W; b++) begin : g_bit
    if (b >= CPU_LSB && b < CPU_LSB + NUM_CPU) begin : g_one
      assign word[b] = 1'b1;
    end else if (b < CPU_LSB) begin : g_cnt
      assign word[b] = 1'(((NUM_CPU - 1) >> b) & 1);
    end else begin : g_zero
      assign word[b] = 1'b0;
    end
  end

endmodule

// File: rtl/snoop_ctl_pwr_bank.sv
module snoop_ctl_pwr_bank
  import snoop_ctl_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [LANE_IDX_W-1:0] lane,
  input  logic [SIZE_W-1:0]     nbytes,
  input  logic [WORD_W-1:0]     wdata,
  output logic [WORD_W-1:0]     word_q
);

  logic [LANES-1:0]  lane_we;
  logic [LANE_W-1:0] lane_d [LANES];
  logic [LANE_W-1:0] lane_q [LANES];

  // Byte b takes source byte (b - lane) when that index is within the access.
  always_comb begin
    for (int b = 0; b < LANES; b++) begin
      int rel;
      rel        = b - int'(lane);
      lane_we[b] = wr_en && (rel >= 0) && (rel < int'(nbytes));
      lane_d[b]  = lane_q[b];
      if (lane_we[b]) begin
        lane_d[b] = wdata[rel*LANE_W +: LANE_W];
      end
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lane_q[g] <= '0;
      end else if (lane_we[g]) begin
        lane_q[g] <= lane_d[g];
      end
    end
    assign word_q[g*LANE_W +: LANE_W] = lane_q[g];
  end

endmodule

// File: rtl/snoop_ctl_regs.sv
module snoop_ctl_regs
  import snoop_ctl_pkg::*;
#(
  parameter int NUM_CPU = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OFS_W-1:0]  bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [SIZE_W-1:0] bus_size,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              bus_err
);

  // R11: core count is limited to the supported range.
  if (NUM_CPU < 1 || NUM_CPU > MAX_CPU) begin : g_bad_cpu_count
    $error("snoop_ctl_regs: NUM_CPU must be between 1 and %0d", MAX_CPU);
  end

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_pipe;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_q_n = rst_pipe[1];

  sel_e                  sel;
  logic [LANE_IDX_W-1:0] lane;
  logic                  size_ok;
  logic                  fault;

  snoop_ctl_decode dec_i (
    .ofs     (bus_addr),
    .size    (bus_size),
    .sel     (sel),
    .lane    (lane),
    .size_ok (size_ok),
    .fault   (fault)
  );

  logic [WORD_W-1:0] ident_word;

  snoop_ctl_ident #(.NUM_CPU(NUM_CPU)) ident_i (
    .word (ident_word)
  );

  logic              pwr_we;
  logic [WORD_W-1:0] pwr_q;

  assign pwr_we = bus_wr && size_ok && (sel == SEL_PWR);

  snoop_ctl_pwr_bank pwr_i (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .wr_en  (pwr_we),
    .lane   (lane),
    .nbytes (bus_size),
    .wdata  (bus_wdata),
    .word_q (pwr_q)
  );

  logic ctrl_q, ctrl_d, ctrl_en;

  assign ctrl_en = bus_wr && size_ok && (sel == SEL_ENABLE);

  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_en) begin
      ctrl_d = bus_wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      ctrl_q <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
    end
  end

  logic [WORD_W-1:0] rd_val;
  logic [WORD_W-1:0] rdata_d, rdata_q;
  logic              err_d, err_q;

  always_comb begin
    rd_val = '0;
    if (!fault) begin
      case (sel)
        SEL_ENABLE: rd_val = {{(WORD_W-1){1'b0}}, ctrl_q};
        SEL_IDENT:  rd_val = ident_word;
        SEL_PWR:    rd_val = pwr_q >> (LANE_W * int'(lane));
        default:    rd_val = '0;
      endcase
    end
  end

  always_comb begin
    rdata_d = rdata_q;
    if (bus_rd) begin
      rdata_d = rd_val;
    end
    err_d = (bus_rd || bus_wr) && fault;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      rdata_q <= rdata_d;
      err_q   <= err_d;
    end
  end

  assign bus_rdata = rdata_q;
  assign bus_err   = err_q;

endmodule

// File: rtl/snoop_ctl_chk.sv
module snoop_ctl_chk
  import snoop_ctl_pkg::*;
#(
  parameter int NUM_CPU = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [OFS_W-1:0]  bus_addr,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic [SIZE_W-1:0] bus_size,
  input logic [WORD_W-1:0] bus_wdata,
  input logic [WORD_W-1:0] bus_rdata,
  input logic              bus_err,
  input logic              ctrl_q,
  input logic [WORD_W-1:0] pwr_q
);

  localparam logic [WORD_W-1:0] IDENT_EXP =
    ((((WORD_W)'(1) << NUM_CPU) - (WORD_W)'(1)) << CPU_LSB) | (WORD_W)'(NUM_CPU - 1);

  logic legal;
  assign legal = (bus_size == 3'd1) || (bus_size == 3'd2) || (bus_size == 3'd4);

  assert_ctrl_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_rd && bus_addr == 8'h00 && legal) |=> (ctrl_q == $past(bus_wdata[0])));

  assert_ident_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 8'h04 && legal) |=> (bus_rdata == IDENT_EXP && !bus_err));

  assert_flush_noop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 8'h0C) |=> ($stable(pwr_q) && $stable(ctrl_q)));

  assert_filter_raz_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && legal && (bus_addr == 8'h40 || bus_addr == 8'h44)) |=> (bus_rdata == '0 && !bus_err));

  assert_acl_unmapped_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_rd || bus_wr) && (bus_addr == 8'h50 || bus_addr == 8'h54)) |=> bus_err);

  assert_bad_size_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_rd || bus_wr) && !legal) |=> (bus_err && $stable(pwr_q) && $stable(ctrl_q)));

  assert_err_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> $past(bus_rd || bus_wr));

  assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));

endmodule

bind snoop_ctl_regs snoop_ctl_chk #(.NUM_CPU(NUM_CPU)) chk_i (
  .clk       (clk),
  .rst_n     (rst_q_n),
  .bus_addr  (bus_addr),
  .bus_rd    (bus_rd),
  .bus_wr    (bus_wr),
  .bus_size  (bus_size),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .bus_err   (bus_err),
  .ctrl_q    (ctrl_q),
  .pwr_q     (pwr_q)
);

// File: tb/snoop_ctl_regs_tb_top.sv
module snoop_ctl_regs_tb_top;

  localparam int TB_CPU = 3;

  logic        clk;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic        bus_rd;
  logic        bus_wr;
  logic [2:0]  bus_size;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        bus_err;

  snoop_ctl_regs #(.NUM_CPU(TB_CPU)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_size  (bus_size),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .bus_err   (bus_err)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;

  logic        m_ctrl;
  logic [31:0] m_pwr;
  logic [31:0] m_rdata;
  logic [31:0] ident_exp;

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic legal(input logic [2:0] sz);
    return sz == 3'd1 || sz == 3'd2 || sz == 3'd4;
  endfunction

  function automatic logic mapped(input logic [7:0] a);
    return a == 8'h00 || a == 8'h04 || (a >= 8'h08 && a <= 8'h0C) || a == 8'h40 || a == 8'h44;
  endfunction

  function automatic string tag_of(input logic [7:0] a, input logic [2:0] sz, input logic wr);
    if (!legal(sz)) return "R9";
    if (a == 8'h00) return "R2";
    if (a == 8'h04) return "R3";
    if (a >= 8'h08 && a <= 8'h0B) return wr ? "R4" : "R5";
    if (a == 8'h0C) return "R6";
    if (a == 8'h40 || a == 8'h44) return "R7";
    return "R8";
  endfunction

  function automatic logic [31:0] model_read(input logic [7:0] a);
    if (a == 8'h00) return {31'b0, m_ctrl};
    if (a == 8'h04) return ident_exp;
    if (a >= 8'h08 && a <= 8'h0B) return m_pwr >> (8 * int'(a - 8'h08));
    return 32'h0;
  endfunction

  // One access, then one idle cycle; checks error, read data and its hold.
  task automatic acc(input logic rd, input logic [7:0] a, input logic [2:0] sz, input logic [31:0] wd);
    string       tag;
    logic        exp_err;
    logic [31:0] exp_data;
    logic [31:0] msk;
    logic [63:0] sh_m, sh_d;
    int          k;
    tag      = tag_of(a, sz, !rd);
    exp_err  = !(legal(sz) && mapped(a));
    exp_data = exp_err ? 32'h0 : model_read(a);
    @(negedge clk);
    bus_addr  = a;
    bus_rd    = rd;
    bus_wr    = !rd;
    bus_size  = sz;
    bus_wdata = wd;
    @(negedge clk);
    bus_rd = 1'b0;
    bus_wr = 1'b0;
    if (rd) begin
      m_rdata = exp_data;
    end else if (!exp_err) begin
      if (a == 8'h00) m_ctrl = wd[0];
      if (a >= 8'h08 && a <= 8'h0B) begin
        k    = 8 * int'(a - 8'h08);
        msk  = (sz == 3'd1) ? 32'hFF : (sz == 3'd2) ? 32'hFFFF : 32'hFFFF_FFFF;
        sh_m = {32'b0, msk} << k;
        sh_d = {32'b0, wd & msk} << k;
        m_pwr = (m_pwr & ~sh_m[31:0]) | sh_d[31:0];
      end
    end
    check(tag, $sformatf("err a=%h sz=%0d rd=%0d", a, sz, rd), {31'b0, bus_err}, {31'b0, exp_err});
    check(rd ? tag : "R10", $sformatf("rdata a=%h sz=%0d rd=%0d", a, sz, rd), bus_rdata, m_rdata);
    @(negedge clk);
    check("R10", "err after idle", {31'b0, bus_err}, 32'h0);
    check("R10", "rdata hold", bus_rdata, m_rdata);
  endtask

  task automatic state_probe(input string tag);
    @(negedge clk);
    bus_addr = 8'h00; bus_rd = 1'b1; bus_size = 3'd4;
    @(negedge clk);
    bus_rd = 1'b0;
    check(tag, "enable bit after stimulus", bus_rdata, {31'b0, m_ctrl});
    @(negedge clk);
    bus_addr = 8'h08; bus_rd = 1'b1; bus_size = 3'd4;
    @(negedge clk);
    bus_rd = 1'b0;
    check(tag, "power word after stimulus", bus_rdata, m_pwr);
    m_rdata = m_pwr;
  endtask

  initial begin
    logic [31:0] pat [4];
    pat[0] = 32'hA5C3_1E77; pat[1] = 32'h5A3C_E188; pat[2] = 32'hFFFF_FFFF; pat[3] = 32'h0102_0304;
    ident_exp = (((32'd1 << TB_CPU) - 32'd1) << 4) | 32'(TB_CPU - 1);
    m_ctrl = 1'b0; m_pwr = 32'h0; m_rdata = 32'h0;
    rst_n = 1'b0; bus_addr = '0; bus_rd = 1'b0; bus_wr = 1'b0; bus_size = 3'd4; bus_wdata = '0;
    repeat (4) @(negedge clk);
    check("R1", "rdata in reset", bus_rdata, 32'h0);
    check("R1", "err in reset", {31'b0, bus_err}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    state_probe("R1");

    // Full read sweep over offsets and size codes (R3/R11 ident at 0x04).
    for (int a = 0; a < 256; a++) begin
      for (int sz = 0; sz < 8; sz++) begin
        acc(1'b1, 8'(a), 3'(sz), 32'h0);
      end
    end

    // Enable bit
    acc(1'b0, 8'h00, 3'd4, 32'hFFFF_FFFF);
    acc(1'b1, 8'h00, 3'd4, 32'h0);
    acc(1'b0, 8'h00, 3'd1, 32'hFFFF_FFFE);
    acc(1'b1, 8'h00, 3'd1, 32'h0);
    acc(1'b0, 8'h00, 3'd2, 32'h0000_0001);
    acc(1'b1, 8'h00, 3'd2, 32'h0);

    // Power status: every lane, every legal size, several patterns.
    for (int p = 0; p < 4; p++) begin
      for (int k = 0; k < 4; k++) begin
        for (int s = 0; s < 3; s++) begin
          acc(1'b0, 8'(8 + k), 3'(1 << s), pat[(p + k + s) % 4] ^ 32'(k * 32'h1111_0000));
          for (int r = 0; r < 4; r++) begin
            acc(1'b1, 8'(8 + r), 3'd4, 32'h0);
          end
        end
      end
    end

    // Writes that must leave state alone.
    acc(1'b0, 8'h04, 3'd4, 32'hFFFF_FFFF);
    state_probe("R3");
    acc(1'b1, 8'h04, 3'd4, 32'h0);
    acc(1'b0, 8'h0C, 3'd4, 32'hFFFF_FFFF);
    state_probe("R6");
    acc(1'b0, 8'h40, 3'd4, 32'hFFFF_FFFF);
    acc(1'b0, 8'h44, 3'd2, 32'hFFFF_FFFF);
    state_probe("R7");
    for (int a = 0; a < 256; a++) begin
      if (!mapped(8'(a))) begin
        acc(1'b0, 8'(a), 3'd4, ~m_pwr);
        state_probe("R8");
      end
    end
    for (int sz = 0; sz < 8; sz++) begin
      if (!legal(3'(sz))) begin
        acc(1'b0, 8'h08, 3'(sz), ~m_pwr);
        acc(1'b0, 8'h00, 3'(sz), {31'b0, ~m_ctrl});
        state_probe("R9");
      end
    end
    summary();
  end

endmodule